// File: doc/BRIEF.md
# Oscillator Trim Calibration Controller

This block tunes the 8-bit trim code of an adjustable on-chip oscillator against a reference pulse of known width, supplied from outside the chip. The block runs from the trimmed bus clock. It counts how many bus clock cycles the reference stays high and compares that count with the count a perfectly tuned clock would give. It turns the relative error into a whole number of trim steps, where one step is taken as 1/512 of the untrimmed frequency. Raising the trim code slows the oscillator, so a fast clock (a count above the expected count) adds steps and a slow clock subtracts them.

One measurement and one correction make up a pass. The block repeats passes on successive reference pulses until a pass computes a correction of zero, and then it raises `done`. If the pulse count overflows, or if the limit on the number of corrections is reached first, it raises `fail` instead. Software or a sequencer pulses `start`, provides one reference pulse per pass and reads `trim`, `done` and `fail`.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, `trim` is 128 (the untrimmed midpoint) and `busy`, `done` and `fail` are all 0.
- R2: A `start` pulse while idle raises `busy` and clears `done` and `fail` on the next cycle. It latches `expected_cnt` and keeps the current `trim`. A `start` while `busy` is high has no effect.
- R3: `ref_pulse` passes through a two-flop synchronizer. A pass counts only after a rising edge seen while armed. The count is the number of clock cycles the synchronized pulse is high, and it ends at the following falling edge.
- R4: The correction magnitude is floor(|count − expected| × 512 / expected), capped at 255. It is added to `trim` when count > expected and subtracted when count < expected.
- R5: The result of a correction saturates: `trim` never wraps below 0 or above 255.
- R6: A pass whose correction is 0 leaves `trim` unchanged, sets `done` and drops `busy`.
- R7: The limit is 8 nonzero corrections in one run. The 8th correction is applied, then `fail` is set and `busy` drops.
- R8: A reference pulse longer than 2^CNT_W − 1 cycles sets `fail`, drops `busy` and leaves `trim` unchanged for that pass.
- R9: A `start` with `expected_cnt` equal to 0 sets `fail` on the next cycle without measuring.
- R10: `done` and `fail` are never high together, and each holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock derived from the trimmed oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a calibration run when idle |
| ref_pulse | input | 1 | Asynchronous reference pulse of known width |
| expected_cnt | input | CNT_W | Cycle count of the reference pulse for a zero-error clock |
| trim | output | 8 | Oscillator trim code; a higher code lowers the frequency |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run converged with a zero correction |
| fail | output | 1 | Run ended by count overflow, the iteration limit or a zero expected count |

## Verification
The expected count is fixed at 1000, and pulse widths are chosen to separate the behaviours. An exact-width pulse checks convergence on the first pass. Widths of 1010 and 990 give a correction of ±5 and check the sign convention. Widths of 1001 and 1002 fall on either side of one step and check that the quotient is truncated. Widths of 2000 and 500 push the correction past the cap and the code against both rails. A run of eight identical fast pulses, with a stray `start` in the middle, checks that the limit is counted across passes and that a restart request is ignored while busy. A pulse longer than the counter range and an expected count of zero each check an early failure that leaves `trim` untouched.

// File: rtl/osc_trim_cal.sv
module osc_trim_cal #(
  parameter int CNT_W      = 16,
  parameter int TRIM_W     = 8,
  parameter int STEP_SHIFT = 9,
  parameter int MAX_ITER   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ref_pulse,
  input  logic [CNT_W-1:0]  expected_cnt,
  output logic [TRIM_W-1:0] trim,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int NUM_W = CNT_W + STEP_SHIFT;
  localparam int BIT_W = $clog2(NUM_W + 1);
  localparam int IT_W  = $clog2(MAX_ITER + 1);
  localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_COUNT, S_DIV, S_APPLY} state_t;
  state_t state;

  logic             ref_s1, ref_s2, ref_d;
  logic [CNT_W-1:0] cnt, exp_q;
  logic             fast;
  logic [NUM_W-1:0] num, quo;
  logic [CNT_W:0]   rem;
  logic [BIT_W-1:0] bits;
  logic [IT_W-1:0]  iter;

  wire rise = ref_s2 & ~ref_d;
  wire [CNT_W-1:0] mag = (cnt > exp_q) ? cnt - exp_q : exp_q - cnt;

  wire [CNT_W:0] rem_sh = {rem[CNT_W-1:0], num[NUM_W-1]};
  wire           ge     = rem_sh >= {1'b0, exp_q};

  wire [TRIM_W-1:0] step = (|quo[NUM_W-1:TRIM_W]) ? {TRIM_W{1'b1}} : quo[TRIM_W-1:0];
  wire [TRIM_W:0]   sum_up = {1'b0, trim} + {1'b0, step};
  wire [TRIM_W-1:0] trim_up = sum_up[TRIM_W] ? {TRIM_W{1'b1}} : sum_up[TRIM_W-1:0];
  wire [TRIM_W-1:0] trim_dn = (step > trim) ? '0 : trim - step;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s1 <= 1'b0;
      ref_s2 <= 1'b0;
      ref_d  <= 1'b0;
    end else begin
      ref_s1 <= ref_pulse;
      ref_s2 <= ref_s1;
      ref_d  <= ref_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      trim  <= TRIM_MID;
      done  <= 1'b0;
      fail  <= 1'b0;
      cnt   <= '0;
      exp_q <= '0;
      fast  <= 1'b0;
      num   <= '0;
      quo   <= '0;
      rem   <= '0;
      bits  <= '0;
      iter  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done  <= 1'b0;
          exp_q <= expected_cnt;
          iter  <= '0;
          if (expected_cnt == '0) fail <= 1'b1;
          else begin
            fail  <= 1'b0;
            state <= S_ARM;
          end
        end
        S_ARM: if (rise) begin
          cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
          state <= S_COUNT;
        end
        S_COUNT: begin
          if (!ref_s2) begin
            fast  <= cnt > exp_q;
            num   <= {mag, {STEP_SHIFT{1'b0}}};
            quo   <= '0;
            rem   <= '0;
            bits  <= '0;
            state <= S_DIV;
          end else if (&cnt) begin
            fail  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DIV: begin
          rem  <= ge ? rem_sh - {1'b0, exp_q} : rem_sh;
          quo  <= {quo[NUM_W-2:0], ge};
          num  <= {num[NUM_W-2:0], 1'b0};
          bits <= bits + 1'b1;
          if (bits == BIT_W'(NUM_W - 1)) state <= S_APPLY;
        end
        S_APPLY: begin
          if (step == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            trim <= fast ? trim_up : trim_dn;
            if (iter == IT_W'(MAX_ITER - 1)) begin
              fail  <= 1'b1;
              state <= S_IDLE;
            end else begin
              iter  <= iter + 1'b1;
              state <= S_ARM;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail)); // R10
  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (done || fail) |-> !busy); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && expected_cnt != '0) |=> (busy && !done && !fail)); // R2
  AST_ZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && expected_cnt == '0) |=> (fail && !busy)); // R9
  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_APPLY) |=> $stable(trim)); // R8
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter < IT_W'(MAX_ITER)); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
endmodule

// File: tb/sim_osc_trim_cal.sv
`timescale 1ns/1ps
module sim_osc_trim_cal;
  localparam int CW = 12;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ref_pulse = 1'b0;
  logic [CW-1:0] expected_cnt = 12'd1000;
  logic [7:0] trim;
  logic busy, done, fail;
  int checks = 0, errors = 0;
  bit finished = 0;

  osc_trim_cal #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_pulse(ref_pulse),
    .expected_cnt(expected_cnt), .trim(trim), .busy(busy), .done(done), .fail(fail));

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model(int tr, int h, int e);
    int d = (h > e) ? h - e : e - h;
    int s = (d * 512) / e;
    if (s > 255) s = 255;
    if (h > e) tr = tr + s; else tr = tr - s;
    if (tr > 255) tr = 255;
    if (tr < 0) tr = 0;
    return tr;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0; ref_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick(int e);
    expected_cnt = CW'(e);
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse(int h);
    ref_pulse = 1'b1;
    repeat (h) @(negedge clk);
    ref_pulse = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 trim", trim, 128); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);   chk("R1 fail", fail, 0);
  endtask

  task automatic t_exact();
    do_reset(); kick(1000);
    chk("R2 busy after start", busy, 1);
    pulse(1000);
    chk("R6 done", done, 1); chk("R6 trim", trim, 128); chk("R6 busy", busy, 0);
    chk("R10 fail low", fail, 0);
    kick(1000);
    chk("R2 done cleared", done, 0);
    pulse(1000);
  endtask

  task automatic t_pair(int h1, string tag);
    int et;
    do_reset(); kick(1000);
    pulse(h1);
    et = model(128, h1, 1000);
    chk({tag, " trim after first pass"}, trim, et);
    pulse(1000);
    chk({tag, " converged"}, done, 1);
    chk({tag, " trim final"}, trim, et);
  endtask

  task automatic t_trunc();
    do_reset(); kick(1000); pulse(1001);
    chk("R3/R4 1001 truncates to 0", trim, 128); chk("R3 done on 1001", done, 1);
    kick(1000); pulse(1002);
    chk("R3/R4 1002 gives +1", trim, 129); chk("R4 still busy", busy, 1);
    pulse(1000);
  endtask

  task automatic t_armed_edge();
    do_reset();
    ref_pulse = 1'b1; repeat (5) @(negedge clk);
    kick(1000); repeat (1500) @(negedge clk);
    ref_pulse = 1'b0; repeat (60) @(negedge clk);
    chk("R3 no count without armed rise", trim, 128); chk("R3 still armed", busy, 1);
    pulse(1010);
    chk("R3 later pulse measured", trim, 133);
    pulse(1000);
  endtask

  task automatic t_limit();
    int et = 128;
    do_reset(); kick(1000);
    for (int i = 0; i < 8; i++) begin
      pulse(1010);
      et = model(et, 1010, 1000);
      if (i == 3) kick(1000);
      if (i == 6) begin chk("R7 busy before limit", busy, 1); chk("R7 trim 7", trim, et); end
    end
    chk("R7 fail", fail, 1); chk("R7 trim 8 applied", trim, et);
    chk("R7 done low", done, 0); chk("R2 start while busy ignored", busy, 0);
  endtask

  task automatic t_overflow();
    do_reset(); kick(1000);
    pulse(5000);
    chk("R8 fail", fail, 1); chk("R8 trim unchanged", trim, 128); chk("R8 busy", busy, 0);
  endtask

  task automatic t_zero_exp();
    do_reset(); kick(0);
    chk("R9 fail", fail, 1); chk("R9 busy", busy, 0); chk("R9 trim", trim, 128);
  endtask

  initial begin
    t_reset();
    t_exact();
    t_pair(1010, "R4 fast");
    t_pair(990,  "R4 slow");
    t_pair(2000, "R5 upper rail");
    t_pair(500,  "R5 lower rail");
    t_trunc();
    t_armed_edge();
    t_limit();
    t_overflow();
    t_zero_exp();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule